// File: doc/BRIEF.md
# Speculation-Tainting Register File

This block is a small integer register file in which every register holds a one-bit taint flag next to its data. A compiler may hoist instructions above a branch and mark them speculative. The file records the failures of those instructions instead of raising them at once. If a speculative instruction hits a terminating exception, the file writes its destination with the taint flag set. If a speculative instruction reads a tainted operand, the taint carries into its destination. Only when a normal instruction reads a tainted operand does the block raise a fault, in the same cycle the instruction is presented. The fault carries the index of the tainted source.

Each issued instruction presents two source indices, an optional destination write, a speculative flag, an exception-valid flag and an exception class. Both read ports are combinational. Writes take effect at the next rising clock edge. A resumable exception, and any exception of a normal instruction, goes straight out on the report output in the same cycle. Handlers, the pipeline and operand forwarding are outside this block.

Top module: `poison_regfile`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads data zero with taint clear.
- R2: Register index 0 always reads data zero with taint clear. Any write to index 0 is ignored, even from a speculative instruction with a terminating exception.
- R3: A speculative instruction (spec=1) with exc_valid=1 and exc_terminating=1 writes its destination with wr_data and taint set. In that cycle exc_report=0 and fault=0.
- R4: A resumable exception (exc_valid=1, exc_terminating=0) drives exc_report=1 and exc_report_term=0 in the same cycle, whether or not spec is set. A speculative instruction still writes its destination. A normal instruction leaves its destination unchanged.
- R5: A speculative instruction that reads a tainted source on either port writes its destination with taint set and raises no fault.
- R6: A normal instruction (spec=0) that reads a tainted source raises fault in the same cycle and leaves its destination unchanged. fault_idx gives src_a_idx when port A is tainted, otherwise src_b_idx. fault_idx is 0 when fault is low.
- R7: fault is high only in a cycle with issue_valid=1, spec=0 and at least one tainted source.
- R8: A normal instruction with no exception and no fault writes wr_data to its destination and clears that register's taint.
- R9: A normal instruction with a terminating exception drives exc_report=1 and exc_report_term=1 in the same cycle and leaves its destination unchanged.
- R10: A speculative instruction with no exception and clean sources writes its destination with taint clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is presented this cycle |
| spec | input | 1 | 1 = speculative instruction, 0 = normal |
| src_a_idx | input | IDX_W | Source A register index |
| src_b_idx | input | IDX_W | Source B register index |
| rd_a_data | output | DATA_W | Source A data |
| rd_a_poison | output | 1 | Source A taint flag |
| rd_b_data | output | DATA_W | Source B data |
| rd_b_poison | output | 1 | Source B taint flag |
| wr_en | input | 1 | Instruction writes a destination |
| wr_idx | input | IDX_W | Destination register index |
| wr_data | input | DATA_W | Destination result value |
| exc_valid | input | 1 | Instruction raised an exception |
| exc_terminating | input | 1 | Exception class: 1 terminating, 0 resumable |
| fault | output | 1 | A normal instruction consumed tainted data |
| fault_idx | output | IDX_W | Index of the tainted source that caused the fault |
| exc_report | output | 1 | Exception passed through at once |
| exc_report_term | output | 1 | Class of the reported exception |

## Verification
The bench builds the file with 8 registers of 16 bits. That makes a scan of every index after reset short, and puts the top index within reach of ordinary stimulus. The bench drives taint along a chain of speculative instructions and then consumes it from normal instructions on each read port separately. It combines both exception classes with both instruction kinds and aims writes at index 0. It then reads destinations back to show which writes were suppressed and which taint flags were set or cleared.

// File: rtl/poison_regfile_pkg.sv
package poison_regfile_pkg;

    typedef enum logic {
        EXC_RESUMABLE   = 1'b0,
        EXC_TERMINATING = 1'b1
    } exc_class_e;

    typedef struct packed {
        logic fault;        // normal instruction consumed tainted data
        logic fault_from_b; // source B picked as the reported index
        logic report;       // exception passed through now
        logic commit;       // destination write goes ahead
        logic taint;        // taint value written with the destination
    } verdict_t;

endpackage

// File: rtl/poison_bank.sv
module poison_bank #(
    parameter int WIDTH   = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [WIDTH-1:0] rd_a_val,
    output logic [WIDTH-1:0] rd_b_val,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_val
);

    logic [ENTRIES-1:0][WIDTH-1:0] slot_d;
    logic [ENTRIES-1:0][WIDTH-1:0] slot_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        if (g == 0) begin : g_zero
            assign slot_d[g] = '0;
        end else begin : g_live
            assign slot_d[g] = (we && wr_idx == IDX_W'(g)) ? wr_val : slot_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_a_val = slot_q[rd_a_idx];
    assign rd_b_val = slot_q[rd_b_idx];

    AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx != '0) |=> (slot_q[$past(wr_idx)] == $past(wr_val))); // R8

    AST_SLOT0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (slot_q[0] == '0)); // R2

endmodule

// File: rtl/poison_decide.sv
module poison_decide
    import poison_regfile_pkg::*;
(
    input  logic     issue_valid,
    input  logic     spec,
    input  logic     taint_a,
    input  logic     taint_b,
    input  logic     exc_valid,
    input  logic     exc_terminating,
    input  logic     wr_en,
    input  logic     dest_nonzero,
    output verdict_t verdict
);

    logic       tainted_src;
    exc_class_e cls;

    always_comb begin
        cls         = exc_class_e'(exc_terminating);
        tainted_src = taint_a || taint_b;
        verdict     = '0;
        if (issue_valid) begin
            verdict.fault        = !spec && tainted_src;
            verdict.fault_from_b = !taint_a;
            verdict.report       = exc_valid && (cls == EXC_RESUMABLE || !spec);
            if (spec) begin
                verdict.commit = wr_en && dest_nonzero;
                verdict.taint  = tainted_src || (exc_valid && cls == EXC_TERMINATING);
            end else begin
                verdict.commit = wr_en && dest_nonzero && !tainted_src && !exc_valid;
                verdict.taint  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
    import poison_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              spec,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_valid,
    input  logic              exc_terminating,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_idx,
    output logic              exc_report,
    output logic              exc_report_term
);

    verdict_t verdict;

    poison_bank #(.WIDTH(DATA_W), .ENTRIES(NREGS)) data_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a_idx),
        .rd_b_idx (src_b_idx),
        .rd_a_val (rd_a_data),
        .rd_b_val (rd_b_data),
        .we       (verdict.commit),
        .wr_idx   (wr_idx),
        .wr_val   (wr_data)
    );

    poison_bank #(.WIDTH(1), .ENTRIES(NREGS)) taint_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a_idx),
        .rd_b_idx (src_b_idx),
        .rd_a_val (rd_a_poison),
        .rd_b_val (rd_b_poison),
        .we       (verdict.commit),
        .wr_idx   (wr_idx),
        .wr_val   (verdict.taint)
    );

    poison_decide decide_i (
        .issue_valid     (issue_valid),
        .spec            (spec),
        .taint_a         (rd_a_poison),
        .taint_b         (rd_b_poison),
        .exc_valid       (exc_valid),
        .exc_terminating (exc_terminating),
        .wr_en           (wr_en),
        .dest_nonzero    (wr_idx != '0),
        .verdict         (verdict)
    );

    assign fault           = verdict.fault;
    assign fault_idx       = !verdict.fault ? '0 :
                             (verdict.fault_from_b ? src_b_idx : src_a_idx);
    assign exc_report      = verdict.report;
    assign exc_report_term = verdict.report && exc_terminating;

    AST_FAULT_NEEDS_TAINT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (issue_valid && !spec && (rd_a_poison || rd_b_poison))); // R7

    AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !verdict.commit); // R6

    AST_SPEC_TERM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && spec && exc_valid && exc_terminating) |-> (!exc_report && !fault)); // R3

    AST_RESUMABLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && exc_valid && !exc_terminating) |-> (exc_report && !exc_report_term)); // R4

    AST_NORMAL_TERM_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !spec && exc_valid && exc_terminating) |-> (exc_report && exc_report_term)); // R9

    AST_CLEAN_COMMIT_UNTAINTED: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.commit && !spec) |-> !verdict.taint); // R8

    AST_SPEC_TAINT_SPREADS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && spec && (rd_a_poison || rd_b_poison) && verdict.commit) |-> verdict.taint); // R5

    AST_IDX0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == '0) |-> (!rd_a_poison && rd_a_data == '0)); // R2

endmodule

// File: tb/poison_regfile_tb_top.sv
`timescale 1ns/1ps
module poison_regfile_tb_top;

    localparam int DW = 16;
    localparam int NR = 8;
    localparam int AW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0, spec = 1'b0;
    logic [AW-1:0] src_a_idx = '0, src_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          rd_a_poison, rd_b_poison;
    logic          wr_en = 1'b0, exc_valid = 1'b0, exc_terminating = 1'b0;
    logic          fault, exc_report, exc_report_term;
    logic [AW-1:0] fault_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    poison_regfile #(.DATA_W(DW), .NREGS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .spec(spec),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .rd_a_data(rd_a_data), .rd_a_poison(rd_a_poison),
        .rd_b_data(rd_b_data), .rd_b_poison(rd_b_poison),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_valid(exc_valid), .exc_terminating(exc_terminating),
        .fault(fault), .fault_idx(fault_idx),
        .exc_report(exc_report), .exc_report_term(exc_report_term)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] ad, bd;
        logic          ap, bp, f, rep, rept;
        logic [AW-1:0] fi;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] m_data [NR];
    logic          m_taint[NR];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(string tag, bit sp, int a, int b, bit we, int w,
                         logic [DW-1:0] d, bit ev, bit et);
        exp_t e;
        bit   pa, pb, commit;
        @(negedge clk);
        issue_valid = 1'b1; spec = sp;
        src_a_idx = AW'(a); src_b_idx = AW'(b);
        wr_en = we; wr_idx = AW'(w); wr_data = d;
        exc_valid = ev; exc_terminating = et;
        pa = m_taint[a]; pb = m_taint[b];
        e.tag  = tag;
        e.ad   = m_data[a]; e.bd = m_data[b];
        e.ap   = pa; e.bp = pb;
        e.f    = !sp && (pa || pb);
        e.fi   = e.f ? (pa ? AW'(a) : AW'(b)) : '0;
        e.rep  = ev && (!et || !sp);
        e.rept = e.rep && et;
        sb.push_back(e);
        commit = we && (w != 0) && (sp || (!(pa || pb) && !ev));
        if (commit) begin
            m_data[w]  = d;
            m_taint[w] = sp ? (pa || pb || (ev && et)) : 1'b0;
        end
    endtask

    task automatic peek(string tag, int a, int b);
        issue(tag, 1'b1, a, b, 1'b0, 0, '0, 1'b0, 1'b0);
    endtask

    always @(negedge clk) begin
        #1;
        if (issue_valid && rst_n) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "rd_a_data",   32'(rd_a_data),   32'(e.ad));
                chk(e.tag, "rd_b_data",   32'(rd_b_data),   32'(e.bd));
                chk(e.tag, "rd_a_poison", 32'(rd_a_poison), 32'(e.ap));
                chk(e.tag, "rd_b_poison", 32'(rd_b_poison), 32'(e.bp));
                chk(e.tag, "fault",       32'(fault),       32'(e.f));
                chk(e.tag, "fault_idx",   32'(fault_idx),   32'(e.fi));
                chk(e.tag, "exc_report",  32'(exc_report),  32'(e.rep));
                chk(e.tag, "exc_report_term", 32'(exc_report_term), 32'(e.rept));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_data[i] = '0; m_taint[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NR; i++) peek("R1", i, i);

        issue("R8", 0, 0, 0, 1, 1, 16'h1111, 0, 0);
        issue("R8", 0, 0, 0, 1, 2, 16'h2222, 0, 0);
        peek("R8", 1, 2);

        issue("R2", 0, 0, 0, 1, 0, 16'hdead, 0, 0);
        issue("R2", 1, 0, 0, 1, 0, 16'hbeef, 1, 1);
        peek("R2", 0, 0);

        issue("R3", 1, 1, 2, 1, 3, 16'h3333, 1, 1);
        peek("R3", 3, 1);

        issue("R5", 1, 1, 3, 1, 4, 16'h4444, 0, 0);
        peek("R5", 4, 2);

        issue("R10", 1, 1, 2, 1, 5, 16'h5555, 0, 0);
        peek("R10", 5, 5);

        issue("R6", 0, 3, 4, 1, 6, 16'h6666, 0, 0);
        issue("R6", 0, 1, 4, 1, 6, 16'h6767, 0, 0);
        peek("R6", 6, 6);

        issue("R4", 0, 1, 2, 1, 7, 16'h7070, 1, 0);
        peek("R4", 7, 7);
        issue("R4", 1, 1, 2, 1, 7, 16'h7777, 1, 0);
        peek("R4", 7, 7);

        issue("R9", 0, 1, 2, 1, 5, 16'h9999, 1, 1);
        peek("R9", 5, 5);

        issue("R7", 1, 3, 4, 0, 0, '0, 0, 0);
        @(negedge clk);
        issue_valid = 1'b0; spec = 1'b0;
        src_a_idx = AW'(3); src_b_idx = AW'(4);
        #1 chk("R7", "fault idle", 32'(fault), 32'd0);

        issue("R8", 0, 1, 2, 1, 3, 16'h3a3a, 0, 0);
        peek("R8", 3, 4);

        @(negedge clk);
        issue_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule